// File: doc/BRIEF.md
# Command-Framed SPI Access Port for Receive and Transmit Byte Queues

This block lets an SPI host drain a receive byte queue and fill a transmit byte queue, each 128 entries deep, through command-framed transfers. The SPI runs in mode 0: the clock idles low, the chip select is active low, bytes go MSB first, and MOSI is sampled on the rising clock edge. The SPI inputs are synchronised into the system clock domain, so the SPI clock has to be well below the system clock (at least eight system clocks per SPI half period). The first byte of a frame is a command byte. Every byte that follows gets a reply byte, shifted out on MISO while that byte is shifted in.

There are three commands. A plain receive read (0x30) pops and returns the oldest receive byte on each data transfer. A copying receive read (0x31) takes two address bytes before its data bytes. Its first reply carries the receive fill count, and every byte it pops is also written to an external memory at consecutive addresses. A transmit write (0x3A) appends each data byte to the transmit queue and replies with the fill count as it stood before that byte went in. Reading from an empty queue and writing to a full one each raise a one-cycle exception pulse. On the far side, a radio-side push port feeds the receive queue and a radio-side pop port drains the transmit queue.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset both queues are empty, `rx_level` and `tx_level` read 0, `spi_miso` is low while `spi_csn` is high, and no memory write occurs.
- R2: After command 0x30, each following byte returns the oldest receive byte and removes it once that byte's first SPI clock edge arrives, so successive bytes come out in push order and `rx_level` drops by one per byte.
- R3: A receive data byte that starts while the receive queue is empty returns 0x00, pulses `rx_underflow` for one cycle, leaves the queue unchanged and writes no memory.
- R4: Command 0x31 is followed by an address-high byte (bits 3:0 give address bits 11:8) and an address-low byte (address bits 7:0). Each byte it pops is written to memory at that address plus n, with n counting successful pops from zero, wrapping modulo 4096.
- R5: With command 0x31, the reply to the address-high byte is the receive fill count, and the reply to the address-low byte is 0x00.
- R6: After command 0x3A, each following byte is appended to the tail of the transmit queue, and the radio-side pop port delivers the bytes in that order.
- R7: During a transmit write, each reply is the transmit fill count before the current byte is entered, so the first data byte of a write into an empty queue returns 0x00.
- R8: A transmit data byte that arrives while the queue holds 128 bytes is discarded, pulses `tx_overflow` for one cycle, returns 0x80 as the count, and leaves `tx_level` at 128.
- R9: The reply to every command byte is 0x00. An unknown command byte makes every later byte of its frame return 0x00, with no effect on either queue or on memory.
- R10: Raising `spi_csn` ends the command. A receive byte that was offered as the next reply but whose transfer never started stays in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI reply data to the host |
| rx_in_valid | input | 1 | Radio-side push into the receive queue (dropped when full) |
| rx_in_data | input | 8 | Byte pushed into the receive queue |
| rx_level | output | 8 | Receive queue fill count |
| tx_out_ready | input | 1 | Radio-side pop from the transmit queue |
| tx_out_data | output | 8 | Oldest byte in the transmit queue |
| tx_level | output | 8 | Transmit queue fill count |
| mem_we | output | 1 | Memory write strobe from the copying read |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rx_underflow | output | 1 | One-cycle pulse: receive read while empty |
| tx_overflow | output | 1 | One-cycle pulse: transmit write while full |

## Verification
The hardest case to reach is the one where a receive byte has already been offered as the next reply but the host deselects the device before clocking it out. The bench creates this by ending a receive-read frame right after the command byte. It then checks that the byte is still in the queue and that it comes back as the first byte of the next frame. Filling the transmit queue to exactly 128 takes a single long write frame that checks every count reply on the way, followed by one extra byte. The address wrap of the copying read is reached by starting the copy at the top address with two bytes queued and a third transfer that underflows.

// File: rtl/spi_fifo_port.sv
module spi_fifo_port #(
  parameter int DEPTH   = 128,
  parameter int MAW     = 12,
  parameter logic [7:0] OP_RD = 8'h30,
  parameter logic [7:0] OP_CP = 8'h31,
  parameter logic [7:0] OP_WR = 8'h3A
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_csn,
  input  logic           spi_sclk,
  input  logic           spi_mosi,
  output logic           spi_miso,
  input  logic           rx_in_valid,
  input  logic [7:0]     rx_in_data,
  output logic [7:0]     rx_level,
  input  logic           tx_out_ready,
  output logic [7:0]     tx_out_data,
  output logic [7:0]     tx_level,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [7:0]     mem_wdata,
  output logic           rx_underflow,
  output logic           tx_overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [2:0] {PH_OPC, PH_AHI, PH_ALO, PH_RXD, PH_TXD, PH_SKIP} phase_t;

  logic [2:0] sclk_s, csn_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [7:0] sh_in, tx_sr, reply;
  logic       pend, ld_pend, cp_mode;
  logic [MAW-1:0] cp_addr;
  phase_t     phase, ph_nxt;

  logic [7:0]    rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] rx_rp, rx_wp, tx_rp, tx_wp;
  logic [CW-1:0] rx_cnt, tx_cnt, tx_cnt_nxt;

  wire cs_act     = !csn_s[1];
  wire rise       = cs_act && sclk_s[1] && !sclk_s[2];
  wire fall       = cs_act && !sclk_s[1] && sclk_s[2];
  wire first_rise = rise && (bit_cnt == 3'd0);
  wire byte_done  = rise && (bit_cnt == 3'd7);
  wire [7:0] byte_in = {sh_in[6:0], mosi_s[1]};
  wire [7:0] rx_head = rx_mem[rx_rp];

  wire rx_push   = rx_in_valid && (rx_cnt != FULL);
  wire rx_pop    = first_rise && (phase == PH_RXD) && pend;
  wire rx_uf_ev  = first_rise && (phase == PH_RXD) && !pend;
  wire tx_pop    = tx_out_ready && (tx_cnt != '0);
  wire tx_push   = byte_done && (phase == PH_TXD) && (tx_cnt != FULL);
  wire tx_ovf_ev = byte_done && (phase == PH_TXD) && (tx_cnt == FULL);

  assign tx_cnt_nxt  = tx_cnt + CW'(tx_push) - CW'(tx_pop);
  assign spi_miso    = cs_act && tx_sr[7];
  assign rx_level    = 8'(rx_cnt);
  assign tx_level    = 8'(tx_cnt);
  assign tx_out_data = tx_mem[tx_rp];

  always_comb begin
    case (phase)
      PH_OPC:  ph_nxt = (byte_in == OP_RD) ? PH_RXD :
                        (byte_in == OP_CP) ? PH_AHI :
                        (byte_in == OP_WR) ? PH_TXD : PH_SKIP;
      PH_AHI:  ph_nxt = PH_ALO;
      PH_ALO:  ph_nxt = PH_RXD;
      default: ph_nxt = phase;
    endcase
    ld_pend = 1'b0;
    case (ph_nxt)
      PH_RXD: begin
        ld_pend = (rx_cnt != '0);
        reply   = ld_pend ? rx_head : 8'h00;
      end
      PH_AHI:  reply = 8'(rx_cnt);
      PH_TXD:  reply = 8'(tx_cnt_nxt);
      default: reply = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= rx_in_data;
    if (tx_push) tx_mem[tx_wp] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0; csn_s <= '1; mosi_s <= '0;
      bit_cnt <= '0; sh_in <= '0; tx_sr <= '0; pend <= 1'b0;
      cp_mode <= 1'b0; cp_addr <= '0; phase <= PH_OPC;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      rx_underflow <= 1'b0; tx_overflow <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      csn_s  <= {csn_s[1:0], spi_csn};
      mosi_s <= {mosi_s[0], spi_mosi};
      mem_we <= 1'b0;
      rx_underflow <= rx_uf_ev;
      tx_overflow  <= tx_ovf_ev;
      if (!cs_act) begin
        bit_cnt <= '0;
        phase   <= PH_OPC;
        tx_sr   <= '0;
        pend    <= 1'b0;
      end else begin
        if (rise) begin
          sh_in   <= byte_in;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall && bit_cnt != 3'd0) tx_sr <= {tx_sr[6:0], 1'b0};
        if (first_rise) pend <= 1'b0;
        if (rx_pop && cp_mode) begin
          mem_we    <= 1'b1;
          mem_addr  <= cp_addr;
          mem_wdata <= rx_head;
          cp_addr   <= cp_addr + 1'b1;
        end
        if (byte_done) begin
          phase <= ph_nxt;
          tx_sr <= reply;
          pend  <= ld_pend;
          case (phase)
            PH_OPC: cp_mode <= (byte_in == OP_CP);
            PH_AHI: cp_addr <= MAW'({byte_in, 8'h00});
            PH_ALO: cp_addr <= {cp_addr[MAW-1:8], byte_in};
            default: ;
          endcase
        end
      end
    end
  end

  // R1: fill counts never exceed the queue depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= 8'(FULL) && tx_level <= 8'(FULL));

  // R3: an underflow leaves the receive count untouched
  a_r3_underflow_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow && !$past(rx_push) |-> rx_level == $past(rx_level));

  // R4: every memory write of the copying read matches one pop
  a_r4_copy_is_pop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(rx_push) |-> rx_level == $past(rx_level) - 8'd1);

  // R6: the transmit count moves by at most one entry per cycle
  a_r6_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level == $past(tx_level) || tx_level == $past(tx_level) + 8'd1 ||
    tx_level == $past(tx_level) - 8'd1);

  // R8: an overflow leaves the transmit queue full
  a_r8_overflow_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow && !$past(tx_pop) |-> tx_level == 8'(FULL));
endmodule

// File: tb/tb_spi_fifo_port.sv
module tb_spi_fifo_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, spi_miso;
  logic rx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0, rx_level, tx_out_data, tx_level, mem_wdata;
  logic mem_we, rx_underflow, tx_overflow;
  logic [11:0] mem_addr;

  always #2 clk = ~clk;

  spi_fifo_port dut (.*);

  int total = 0, bad = 0, uf_n = 0, of_n = 0, mw_n = 0;
  bit done = 0;
  logic [11:0] mw_a [8];
  logic [7:0]  mw_d [8];

  always @(posedge clk) if (rst_n) begin
    if (rx_underflow) uf_n <= uf_n + 1;
    if (tx_overflow)  of_n <= of_n + 1;
    if (mem_we) begin
      if (mw_n < 8) begin mw_a[mw_n] <= mem_addr; mw_d[mw_n] <= mem_wdata; end
      mw_n <= mw_n + 1;
    end
  end

  // {last, req, mosi, expected reply}
  localparam logic [20:0] VEC [15] = '{
    {1'b0, 4'd9, 8'h30, 8'h00}, {1'b0, 4'd2, 8'h00, 8'hA1}, {1'b1, 4'd2, 8'h00, 8'hB2},
    {1'b0, 4'd9, 8'h3A, 8'h00}, {1'b0, 4'd7, 8'h11, 8'h00}, {1'b0, 4'd7, 8'h22, 8'h01},
    {1'b1, 4'd7, 8'h33, 8'h02},
    {1'b0, 4'd9, 8'h31, 8'h00}, {1'b0, 4'd5, 8'h05, 8'h03}, {1'b0, 4'd5, 8'h7E, 8'h00},
    {1'b0, 4'd2, 8'h00, 8'hC3}, {1'b1, 4'd2, 8'h00, 8'hD4},
    {1'b0, 4'd9, 8'h55, 8'h00}, {1'b1, 4'd9, 8'hFF, 8'h00},
    {1'b0, 4'd7, 8'h3A, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    spi_csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (8) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = o[i];
      repeat (8) @(negedge clk);
      r[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk); rx_in_valid = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] d);
    @(negedge clk); d = tx_out_data; tx_out_ready = 1'b1;
    @(negedge clk); tx_out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d;
    int errs;
    bit open;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rx_level == 0 && tx_level == 0, "R1 levels", {rx_level, tx_level}, 0);
    chk(spi_miso == 1'b0 && mw_n == 0, "R1 miso/mem", spi_miso, 0);

    push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3); push_rx(8'hD4); push_rx(8'hE5);

    open = 0;
    for (int k = 0; k < 15; k++) begin
      if (!open) begin cs_on(); open = 1; end
      xfer(VEC[k][15:8], r);
      chk(r == VEC[k][7:0], $sformatf("R%0d vector %0d", VEC[k][19:16], k), r, VEC[k][7:0]);
      if (VEC[k][20]) begin cs_off(); open = 0; end
    end
    xfer(8'h44, r);
    chk(r == 8'h03, "R7 fourth byte count", r, 8'h03);
    cs_off();

    chk(rx_level == 1, "R2 rx level after reads", rx_level, 1);
    chk(mw_n == 2, "R4 copy write count", mw_n, 2);
    chk(mw_a[0] == 12'h57E && mw_d[0] == 8'hC3, "R4 first copy", {mw_a[0], mw_d[0]}, 20'h57EC3);
    chk(mw_a[1] == 12'h57F && mw_d[1] == 8'hD4, "R4 second copy", {mw_a[1], mw_d[1]}, 20'h57FD4);
    chk(tx_level == 4 && uf_n == 0 && of_n == 0, "R9 unknown command had no effect", tx_level, 4);
    pop_tx(d); chk(d == 8'h11, "R6 tx order 0", d, 8'h11);
    pop_tx(d); chk(d == 8'h22, "R6 tx order 1", d, 8'h22);
    pop_tx(d); chk(d == 8'h33, "R6 tx order 2", d, 8'h33);
    pop_tx(d); chk(d == 8'h44, "R6 tx order 3", d, 8'h44);
    chk(tx_level == 0, "R6 tx drained", tx_level, 0);

    // R10 abort after the command: the offered byte stays queued
    cs_on(); xfer(8'h30, r); cs_off();
    chk(rx_level == 1, "R10 byte kept after abort", rx_level, 1);
    cs_on();
    xfer(8'h30, r);
    xfer(8'h00, r); chk(r == 8'hE5, "R10 kept byte returned", r, 8'hE5);
    xfer(8'h00, r); chk(r == 8'h00, "R3 underflow reply", r, 8'h00);
    cs_off();
    chk(uf_n == 1 && rx_level == 0, "R3 underflow pulse/level", {uf_n[7:0], rx_level}, 16'h0100);

    // R4 address wrap, R3 underflow during copy
    push_rx(8'h5A); push_rx(8'h6B);
    cs_on();
    xfer(8'h31, r);
    xfer(8'h0F, r); chk(r == 8'h02, "R5 count reply", r, 8'h02);
    xfer(8'hFF, r); chk(r == 8'h00, "R5 address-low reply", r, 8'h00);
    xfer(8'h00, r); chk(r == 8'h5A, "R4 copy data 0", r, 8'h5A);
    xfer(8'h00, r); chk(r == 8'h6B, "R4 copy data 1", r, 8'h6B);
    xfer(8'h00, r); chk(r == 8'h00, "R3 copy underflow reply", r, 8'h00);
    cs_off();
    chk(mw_n == 4, "R3 no write on underflow", mw_n, 4);
    chk(mw_a[2] == 12'hFFF && mw_d[2] == 8'h5A, "R4 top address", {mw_a[2], mw_d[2]}, 20'hFFF5A);
    chk(mw_a[3] == 12'h000 && mw_d[3] == 8'h6B, "R4 wrapped address", {mw_a[3], mw_d[3]}, 20'h0006B);
    chk(uf_n == 2, "R3 second underflow pulse", uf_n, 2);

    // R8 fill to exactly full, then one more byte
    cs_on();
    xfer(8'h3A, r);
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      xfer(8'(i), r);
      if (r != 8'(i)) errs++;
    end
    chk(errs == 0, "R7 count replies while filling", errs, 0);
    xfer(8'h99, r); chk(r == 8'h80, "R8 full count reply", r, 8'h80);
    cs_off();
    chk(of_n == 1 && tx_level == 8'd128, "R8 overflow pulse/level", {of_n[7:0], tx_level}, 16'h0180);
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      pop_tx(d);
      if (d != 8'(i)) errs++;
    end
    chk(errs == 0 && tx_level == 0, "R8 overflow byte discarded", errs, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule